// File: doc/BRIEF.md
# Memory clock reprogramming sequencer

The block is a register-bus master that moves the memory clock to a new frequency without a glitch on its output. On a start pulse it captures the target divider values (N, M, P). It first tunes the pixel-clock PLL to that same frequency and parks the memory-clock output on the dot clock, which this PLL now drives. It then disables, reprograms and re-enables the memory-clock PLL and switches the output back to it. The output multiplexer is moved only through strobed writes to a clock-control register.

Each PLL has five registers at a base address: a control register whose bit 0 enables the PLL (offset 0), the N, M and P values (offsets 1, 2, 3), and a status register whose bit 0 is the lock flag (offset 4). A source-select register chooses the dot-clock source, with bit 0 = 1 meaning the pixel PLL. In the clock-control register, bit 4 is the memory-clock multiplexer select (1 = memory PLL, 0 = dot clock). Bit 3 is its strobe: a 0-to-1 change of bit 3 loads bit 4. The bus is a request/acknowledge handshake. A request stays up with stable fields until the acknowledge arrives, and read data is valid together with the acknowledge.

Top module: `mclk_retune_seq`

## Requirements
- R1: After reset, busy, done, err and bus_req are all low.
- R2: After an accepted start, the first five bus transactions are writes to the pixel PLL: control=0, then N, M, P with the captured targets, then control=1.
- R3: The pixel PLL status register is then read repeatedly. The sequencer moves on only after a read whose bit 0 is 1.
- R4: The source-select register is read next. If bit 0 is 0, it is written back with bit 0 set and every other bit unchanged. If bit 0 is 1, no write to it follows.
- R5: The clock-control register is then read and written twice, with bits 4:3 equal to 00 and then 01. All other bits keep the value that was read.
- R6: The memory PLL then receives control=0, N, M, P and control=1. Its status is polled until bit 0 reads 1.
- R7: Finally, the clock-control register is read again and written with bits 4:3 equal to 10 and then 11. All other bits keep the value that was read.
- R8: No clock-control write that takes bit 3 from 0 to 1 also changes bit 4.
- R9: If a status poll returns lock=0 after POLL_LIMIT or more cycles in that poll step, the sequence stops: err goes high, busy goes low and no further bus request is made. After a memory-PLL poll timeout, bits 4:3 of the control register are 01. err stays high until the next accepted start, which clears it.
- R10: A start while busy is ignored. The targets captured at the accepted start are used, and no extra transactions appear after completion.
- R11: done is high for exactly one cycle, after the acknowledge of the final write, with busy low from that cycle on. done is never high together with err.
- R12: Once bus_req is high without bus_ack, it stays high next cycle with bus_we, bus_addr and bus_wdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| tgt_n | input | DW | Target N value |
| tgt_m | input | DW | Target M value |
| tgt_p | input | DW | Target P value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Lock poll timed out (sticky until next start) |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Transaction acknowledge |
| bus_rdata | input | DW | Read data, valid with bus_ack |

## Verification
The sequence is run from a control register whose multiplexer bits start at 11, then at 00, with different surrounding bits each time. This shows that the read-modify-write keeps those bits and does not just write constants. Two source-select values are used: one with bit 0 clear, which must produce a write, and one with it set, which must not. A stray start with different targets partway through a run shows whether the captured values are kept. A memory PLL that never locks drives the timeout path, and a normal run afterwards shows that err is cleared and the block recovers.

// File: rtl/mclk_seq_pkg.sv
package mclk_seq_pkg;

    typedef enum logic [1:0] {
        OP_WR      = 2'd0,
        OP_RD_SRC  = 2'd1,
        OP_RD_CTL  = 2'd2,
        OP_POLL    = 2'd3
    } op_e;

    // register offsets inside one PLL register set
    localparam int OFS_CTL  = 0;
    localparam int OFS_N    = 1;
    localparam int OFS_M    = 2;
    localparam int OFS_P    = 3;
    localparam int OFS_STAT = 4;

    // bit positions
    localparam int EN_BIT   = 0;
    localparam int LOCK_BIT = 0;
    localparam int SRC_BIT  = 0;
    localparam int STB_BIT  = 3;
    localparam int MUX_BIT  = 4;

    // step indices of the sequence
    localparam int STEP_PIX     = 0;
    localparam int STEP_SRC_RD  = 6;
    localparam int STEP_SRC_WR  = 7;
    localparam int STEP_CTL_RD1 = 8;
    localparam int STEP_PARK0   = 9;
    localparam int STEP_PARK1   = 10;
    localparam int STEP_MCL     = 11;
    localparam int STEP_CTL_RD2 = 17;
    localparam int STEP_BACK0   = 18;
    localparam int STEP_BACK1   = 19;
    localparam int LAST_STEP    = STEP_BACK1;
    localparam int PLL_STEPS    = 6;

endpackage

// File: rtl/mclk_seq_step_rom.sv
module mclk_seq_step_rom
    import mclk_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int SW = 5,
    parameter logic [AW-1:0] PIX_BASE = 8'h00,
    parameter logic [AW-1:0] MCL_BASE = 8'h08,
    parameter logic [AW-1:0] SRC_ADDR = 8'h10,
    parameter logic [AW-1:0] CTL_ADDR = 8'h11
) (
    input  logic [SW-1:0] step,
    input  logic [DW-1:0] n,
    input  logic [DW-1:0] m,
    input  logic [DW-1:0] p,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] ctl,
    output op_e           op,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    localparam logic [DW-1:0] EN_VAL   = DW'(1) << EN_BIT;
    localparam logic [DW-1:0] MUX_VAL  = DW'(1) << MUX_BIT;
    localparam logic [DW-1:0] STB_VAL  = DW'(1) << STB_BIT;
    localparam logic [DW-1:0] SRC_VAL  = DW'(1) << SRC_BIT;
    localparam logic [DW-1:0] KEEP_MSK = ~(MUX_VAL | STB_VAL);

    logic [DW-1:0] ctl_keep;
    logic [SW-1:0] pll_idx;
    logic [AW-1:0] pll_base;
    logic          in_pll;

    assign ctl_keep = ctl & KEEP_MSK;

    always_comb begin
        in_pll   = 1'b0;
        pll_idx  = '0;
        pll_base = PIX_BASE;
        if (int'(step) < PLL_STEPS) begin
            in_pll  = 1'b1;
            pll_idx = step;
        end else if (int'(step) >= STEP_MCL && int'(step) < STEP_MCL + PLL_STEPS) begin
            in_pll   = 1'b1;
            pll_idx  = step - SW'(STEP_MCL);
            pll_base = MCL_BASE;
        end
    end

    always_comb begin
        op    = OP_WR;
        addr  = '0;
        wdata = '0;
        if (in_pll) begin
            case (int'(pll_idx))
                0: begin addr = pll_base + AW'(OFS_CTL); wdata = '0; end
                1: begin addr = pll_base + AW'(OFS_N);   wdata = n;  end
                2: begin addr = pll_base + AW'(OFS_M);   wdata = m;  end
                3: begin addr = pll_base + AW'(OFS_P);   wdata = p;  end
                4: begin addr = pll_base + AW'(OFS_CTL); wdata = EN_VAL; end
                default: begin op = OP_POLL; addr = pll_base + AW'(OFS_STAT); end
            endcase
        end else begin
            case (int'(step))
                STEP_SRC_RD:  begin op = OP_RD_SRC; addr = SRC_ADDR; end
                STEP_SRC_WR:  begin addr = SRC_ADDR; wdata = src | SRC_VAL; end
                STEP_CTL_RD1,
                STEP_CTL_RD2: begin op = OP_RD_CTL; addr = CTL_ADDR; end
                STEP_PARK0:   begin addr = CTL_ADDR; wdata = ctl_keep; end
                STEP_PARK1:   begin addr = CTL_ADDR; wdata = ctl_keep | STB_VAL; end
                STEP_BACK0:   begin addr = CTL_ADDR; wdata = ctl_keep | MUX_VAL; end
                STEP_BACK1:   begin addr = CTL_ADDR; wdata = ctl_keep | MUX_VAL | STB_VAL; end
                default:      begin addr = '0; wdata = '0; end
            endcase
        end
    end
endmodule

// File: rtl/mclk_seq_poll_timer.sv
module mclk_seq_poll_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = (cnt_q == LIM) ? cnt_q : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM);
endmodule

// File: rtl/mclk_retune_seq.sv
module mclk_retune_seq
    import mclk_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [AW-1:0] PIX_BASE = 8'h00,
    parameter logic [AW-1:0] MCL_BASE = 8'h08,
    parameter logic [AW-1:0] SRC_ADDR = 8'h10,
    parameter logic [AW-1:0] CTL_ADDR = 8'h11,
    parameter int POLL_LIMIT = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] tgt_n,
    input  logic [DW-1:0] tgt_m,
    input  logic [DW-1:0] tgt_p,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);
    localparam int SW = $clog2(LAST_STEP + 1);

    typedef struct packed {
        logic          busy;
        logic          req;
        logic [SW-1:0] step;
        logic [DW-1:0] n;
        logic [DW-1:0] m;
        logic [DW-1:0] p;
        logic [DW-1:0] src;
        logic [DW-1:0] ctl;
        logic          done;
        logic          err;
    } seq_t;

    seq_t d, q;
    op_e  op;
    logic poll_run, poll_expired;

    mclk_seq_step_rom #(
        .AW(AW), .DW(DW), .SW(SW),
        .PIX_BASE(PIX_BASE), .MCL_BASE(MCL_BASE),
        .SRC_ADDR(SRC_ADDR), .CTL_ADDR(CTL_ADDR)
    ) i_rom (
        .step(q.step), .n(q.n), .m(q.m), .p(q.p), .src(q.src), .ctl(q.ctl),
        .op(op), .addr(bus_addr), .wdata(bus_wdata)
    );

    assign poll_run = q.busy && (op == OP_POLL);

    mclk_seq_poll_timer #(.LIMIT(POLL_LIMIT)) i_timer (
        .clk(clk), .rst_n(rst_n), .run(poll_run), .expired(poll_expired)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.req  = 1'b1;
                d.step = SW'(STEP_PIX);
                d.n    = tgt_n;
                d.m    = tgt_m;
                d.p    = tgt_p;
                d.err  = 1'b0;
            end
        end else if (!q.req) begin
            d.req = 1'b1;
        end else if (bus_ack) begin
            d.req = 1'b0;
            case (op)
                OP_WR: begin
                    if (int'(q.step) == LAST_STEP) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.step = q.step + SW'(1);
                    end
                end
                OP_RD_SRC: begin
                    d.src  = bus_rdata;
                    d.step = q.step + (bus_rdata[SRC_BIT] ? SW'(2) : SW'(1));
                end
                OP_RD_CTL: begin
                    d.ctl  = bus_rdata;
                    d.step = q.step + SW'(1);
                end
                OP_POLL: begin
                    if (bus_rdata[LOCK_BIT]) begin
                        d.step = q.step + SW'(1);
                    end else if (poll_expired) begin
                        d.busy = 1'b0;
                        d.err  = 1'b1;
                    end
                end
                default: d.step = q.step;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign err     = q.err;
    assign bus_req = q.req;
    assign bus_we  = (op == OP_WR);
endmodule

// File: rtl/mclk_seq_checker.sv
module mclk_seq_checker
    import mclk_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter logic [AW-1:0] CTL_ADDR = 8'h11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_ack
);
    logic [DW-1:0] last_q;
    logic          have_q;
    logic          ctl_wr;

    assign ctl_wr = bus_req && bus_ack && bus_we && (bus_addr == CTL_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            have_q <= 1'b0;
        end else if (ctl_wr) begin
            last_q <= bus_wdata;
            have_q <= 1'b1;
        end
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    p_strobe_mux_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && have_q && bus_wdata[STB_BIT] && !last_q[STB_BIT])
            |-> (bus_wdata[MUX_BIT] == last_q[MUX_BIT]));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !bus_ack) |=> busy);

    p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> !err);
endmodule

bind mclk_retune_seq mclk_seq_checker #(
    .AW(AW), .DW(DW), .CTL_ADDR(CTL_ADDR)
) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/test_mclk_retune_seq.sv
module test_mclk_retune_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PC = 8'h00, PN = 8'h01, PM = 8'h02, PP = 8'h03, PST = 8'h04;
    localparam logic [7:0] MC = 8'h08, MN = 8'h09, MM = 8'h0A, MP = 8'h0B, MST = 8'h0C;
    localparam logic [7:0] SRC = 8'h10, CTL = 8'h11;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] tgt_n = '0, tgt_m = '0, tgt_p = '0;
    logic busy, done, err, bus_req, bus_we, bus_ack;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mclk_retune_seq i_mclk_retune_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tgt_n(tgt_n), .tgt_m(tgt_m), .tgt_p(tgt_p),
        .busy(busy), .done(done), .err(err),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // ---------------- register-file slave with PLL lock models
    logic [7:0] regs [0:31];
    logic ld = 1'b0;
    logic [7:0] ld_src = '0, ld_ctl = '0;
    int pdly = 4, mdly = 4;
    int pcnt, mcnt;
    logic pen, men;
    logic plk, mlk;
    assign plk = pen && (pcnt == 0);
    assign mlk = men && (mcnt == 0);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; bus_rdata <= '0;
            pen <= 1'b0; men <= 1'b0; pcnt <= 0; mcnt <= 0;
        end else begin
            if (pen && pcnt > 0) pcnt <= pcnt - 1;
            if (men && mcnt > 0) mcnt <= mcnt - 1;
            if (ld) begin
                regs[SRC[4:0]] <= ld_src;
                regs[CTL[4:0]] <= ld_ctl;
            end
            bus_ack <= 1'b0;
            if (bus_req && !bus_ack) begin
                bus_ack <= 1'b1;
                if (bus_we) begin
                    regs[bus_addr[4:0]] <= bus_wdata;
                    if (bus_addr == PC) begin pen <= bus_wdata[0]; pcnt <= pdly; end
                    if (bus_addr == MC) begin men <= bus_wdata[0]; mcnt <= mdly; end
                end else if (bus_addr == PST) bus_rdata <= {7'b0, plk};
                else if (bus_addr == MST)     bus_rdata <= {7'b0, mlk};
                else                          bus_rdata <= regs[bus_addr[4:0]];
            end
        end
    end

    // ---------------- scoreboard
    typedef struct {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
        string      tag;
    } txn_t;
    txn_t exp_q[$];

    int total = 0, bad = 0;
    int mon_total = 0, mon_bad = 0;
    int done_cnt = 0, req_cnt = 0;

    task automatic push(input logic we, input logic [7:0] a, input logic [7:0] dt, input string tag);
        txn_t t;
        t.we = we; t.addr = a; t.data = dt; t.tag = tag;
        exp_q.push_back(t);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // monitor
    logic stat_seen = 1'b0, stat_val = 1'b0;
    string stat_tag = "R3";
    logic prev_wait = 1'b0;
    logic [7:0] prev_addr = '0, prev_wdata = '0, shadow_ctl = '0;
    logic prev_we = 1'b0, have_ctl = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (bus_req) req_cnt++;
            if (err) stat_seen = 1'b0;
            // R12: held request keeps its fields
            if (prev_wait) begin
                mon_total++;
                if (!(bus_req && bus_addr == prev_addr && bus_we == prev_we && bus_wdata == prev_wdata)) begin
                    mon_bad++;
                    $display("FAIL R12 actual=%0h expected=%0h", bus_addr, prev_addr);
                end
            end
            prev_wait  = bus_req && !bus_ack;
            prev_addr  = bus_addr; prev_we = bus_we; prev_wdata = bus_wdata;

            if (bus_req && bus_ack) begin
                if (!bus_we && (bus_addr == PST || bus_addr == MST)) begin
                    stat_seen = 1'b1;
                    stat_val  = bus_rdata[0];
                    stat_tag  = (bus_addr == PST) ? "R3" : "R6";
                end else begin
                    if (stat_seen) begin
                        mon_total++;
                        if (!stat_val) begin
                            mon_bad++;
                            $display("FAIL %s actual=%0h expected=%0h", stat_tag, stat_val, 1);
                        end
                        stat_seen = 1'b0;
                    end
                    if (bus_we && bus_addr == CTL) begin
                        // R8: strobe rise never carries a mux change
                        if (have_ctl && bus_wdata[3] && !shadow_ctl[3]) begin
                            mon_total++;
                            if (bus_wdata[4] != shadow_ctl[4]) begin
                                mon_bad++;
                                $display("FAIL R8 actual=%0h expected=%0h", bus_wdata[4], shadow_ctl[4]);
                            end
                        end
                        shadow_ctl = bus_wdata;
                        have_ctl   = 1'b1;
                    end
                    mon_total++;
                    if (exp_q.size() == 0) begin
                        mon_bad++;
                        $display("FAIL R10 actual=%0h expected=%0h", bus_addr, 0);
                    end else begin
                        txn_t e;
                        e = exp_q.pop_front();
                        if (bus_we != e.we || bus_addr != e.addr || (e.we && bus_wdata != e.data)) begin
                            mon_bad++;
                            $display("FAIL %s actual=%0h expected=%0h", e.tag,
                                     {bus_we, bus_addr, bus_wdata}, {e.we, e.addr, e.data});
                        end
                    end
                end
            end
        end
    end

    // ---------------- driver
    task automatic run_seq(input logic [7:0] n, input logic [7:0] m, input logic [7:0] p,
                           input logic [7:0] src0, input logic [7:0] ctl0,
                           input int pd, input int md, input bit mfail, input bit poke);
        logic [7:0] k;
        int d0, guard;
        @(negedge clk);
        ld_src = src0; ld_ctl = ctl0; pdly = pd; mdly = md; ld = 1'b1;
        @(negedge clk);
        ld = 1'b0;
        k = ctl0 & 8'hE7;
        push(1, PC, 8'h00, "R2"); push(1, PN, n, "R2"); push(1, PM, m, "R2");
        push(1, PP, p, "R2");     push(1, PC, 8'h01, "R2");
        push(0, SRC, 8'h00, "R4");
        if (!src0[0]) push(1, SRC, src0 | 8'h01, "R4");
        push(0, CTL, 8'h00, "R5"); push(1, CTL, k, "R5"); push(1, CTL, k | 8'h08, "R5");
        push(1, MC, 8'h00, "R6"); push(1, MN, n, "R6"); push(1, MM, m, "R6");
        push(1, MP, p, "R6");     push(1, MC, 8'h01, "R6");
        if (!mfail) begin
            push(0, CTL, 8'h00, "R7"); push(1, CTL, k | 8'h10, "R7"); push(1, CTL, k | 8'h18, "R7");
        end
        d0 = done_cnt;
        tgt_n = n; tgt_m = m; tgt_p = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && err == 1'b0, "R9 start clears err, sets busy", {busy, err}, 2'b10);
        if (poke) begin
            repeat (10) @(negedge clk);
            tgt_n = ~n; tgt_m = ~m; start = 1'b1;   // R10: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!(done || err) && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 4000, "watchdog", guard, 4000);
        if (mfail) begin
            chk(err == 1'b1 && busy == 1'b0, "R9 err/busy", {err, busy}, 2'b10);
            chk(regs[CTL[4:0]][4:3] == 2'b01, "R9 parked on dot clock", regs[CTL[4:0]][4:3], 1);
        end else begin
            chk(done == 1'b1 && busy == 1'b0, "R11 done with busy low", {done, busy}, 2'b10);
            @(negedge clk);
            chk(done == 1'b0, "R11 done one cycle", done, 0);
            chk(regs[CTL[4:0]] == (k | 8'h18), "R7 final control", regs[CTL[4:0]], k | 8'h18);
        end
        begin
            int r0;
            r0 = req_cnt;
            repeat (16) @(negedge clk);
            chk(req_cnt == r0, "R10/R9 bus quiet after end", req_cnt - r0, 0);
        end
        chk(done_cnt - d0 == (mfail ? 0 : 1), "R11 done count", done_cnt - d0, mfail ? 0 : 1);
        chk(exp_q.size() == 0, "R2 all expected transactions seen", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0 && bus_req == 0, "R1 reset state",
            {busy, done, err, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req == 1'b0 && busy == 1'b0, "R1 idle after reset", {bus_req, busy}, 0);
        // mux at 11, source needs a write
        run_seq(8'h1C, 8'h35, 8'h02, 8'h40, 8'hFA, 5, 7, 0, 0);
        // mux at 00, source already pixel PLL, stray start mid-run
        run_seq(8'h27, 8'h11, 8'h03, 8'h81, 8'h07, 9, 3, 0, 1);
        // memory PLL never locks
        run_seq(8'h0F, 8'h22, 8'h01, 8'h00, 8'h18, 2, 5000, 1, 0);
        // recovery after timeout
        run_seq(8'h3A, 8'h19, 8'h00, 8'h41, 8'h66, 3, 12, 0, 0);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total + mon_total, bad + mon_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("test done: total=%0d bad=%0d", total + mon_total + 1, bad + mon_bad + 1);
        $finish;
    end
endmodule